// File: doc/BRIEF.md
# Paged Edge-Interrupt GPIO Controller

This block gives a host a byte-wide register window onto 48 general-purpose pins. The pins are grouped as six ports of eight. Each pin has a pull-down style driver. A data bit of 1 pulls the pin low, and a data bit of 0 releases it so the pin can act as an input. Reading a data offset returns the pin level after synchronisation, not the value that was written.

The lower three ports, pins 0 to 23, also have edge detection. Each of these pins can be set to catch either a rising or a falling edge. When an enabled pin sees its chosen edge, an identification bit latches. Three offsets (8 to 10) are shared by the per-port polarity, enable and identification banks. A page field at offset 7 chooses which bank those offsets show.

Offset 6 reports one pending flag per edge-capable port, and a single interrupt line is raised while any flag is set. Software acknowledges an event by writing the enable bit to 0, which clears the latched bit, and then writing it back to 1.

Top module: `pgpio_ctrl`

## Requirements
- R1: Offsets 0 to 5 hold one data byte per port, and port k drives pin_pull[8k+7:8k]. A 1 pulls the pin, a 0 releases it, and all data bits are 0 after reset.
- R2: Reading offsets 0 to 5 returns the pin levels through a two-flop synchroniser. A change on pin_in before clock edge n is seen on a read after edge n+1 and is not seen after edge n alone.
- R3: The page field is bits 7:6 of offset 7. A read of offset 7 returns the page field in bits 7:6 and 0 in bits 5:0, and the field is 0 after reset.
- R4: The page field selects the bank at offsets 8, 9 and 10 (port 0, 1, 2): page 1 is polarity (read/write), page 2 is enable (read/write), page 3 is identification (read only; writes ignored). With page 0 these offsets read 0 and writes to them are ignored.
- R5: With its enable bit at 1, an identification bit latches on a rising edge when its polarity bit is 1, and on a falling edge when it is 0. A pin change before edge n latches at edge n+2. An edge of the other direction latches nothing, and ports 3 to 5 never raise an event.
- R6: Writing 0 to an enable bit clears its identification bit. When that write lands in the same cycle as a qualifying edge on that bit, the clear wins. Other bits of the same port keep latching in that cycle. An edge seen in the same cycle that an enable bit goes from 0 to 1 is not latched.
- R7: Offset 6 reads the pending flags in bits 2:0, one per port 0 to 2, with bits 7:3 as 0. Each flag is set while any identification bit of its port is 1. Writes to offset 6 are ignored.
- R8: irq_out is the OR of the three pending flags. Once set, it stays high until every latched identification bit has been cleared by enable writes.
- R9: After reset all enable bits are 0. An identification bit is never 1 while its enable bit is 0, so nothing latches before software configures the block.
- R10: Offsets 11 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 48 | Pin levels (asynchronous) |
| pin_pull | output | 48 | 1 = pull pin low, 0 = released |
| irq_out | output | 1 | Interrupt request |

## Verification
The contested cycle is a host enable write that lands on the same clock edge as a detected pin edge within the same port. The bench changes two pins of port 2, counts the two synchroniser stages, and times the enable write so it is captured on exactly the edge where detection fires. It then expects the bit being cleared to stay clear while its neighbour latches. A second case times an enable 0-to-1 write against an edge on that bit and expects no latch.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;
  localparam int PG_PORT_W     = 8;
  localparam int PG_NUM_PORTS  = 6;
  localparam int PG_EDGE_PORTS = 3;

  // Bank selector held in the upper two bits of the page register
  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;
endpackage

// File: rtl/pgpio_sync.sv
module pgpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= async_in;
      s2_q <= s1_q;
    end
  end

  assign sync_out = s2_q;
endmodule

// File: rtl/pgpio_edge_bank.sv
module pgpio_edge_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic         pol_we,
  input  logic         en_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] id_q,
  output logic         pend
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pol_d, en_d, id_d;
  logic [W-1:0] rise, fall, hit;

  always_comb begin
    rise  = lvl & ~prev_q;
    fall  = ~lvl & prev_q;
    // Current polarity decides; a polarity write acts from next cycle
    hit   = (pol_q & rise) | (~pol_q & fall);
    pol_d = pol_we ? wdata : pol_q;
    en_d  = en_we ? wdata : en_q;
    // R6: a cleared enable wins; an edge needs the enable already set
    id_d  = en_d & (id_q | (hit & en_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      id_q   <= '0;
    end else begin
      prev_q <= lvl;
      pol_q  <= pol_d;
      en_q   <= en_d;
      id_q   <= id_d;
    end
  end

  assign pend = |id_q;
endmodule

// File: rtl/pgpio_ctrl.sv
module pgpio_ctrl
  import pgpio_pkg::*;
#(
  parameter int PORT_W     = PG_PORT_W,
  parameter int NUM_PORTS  = PG_NUM_PORTS,
  parameter int EDGE_PORTS = PG_EDGE_PORTS,
  parameter int ADDR_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [PORT_W-1:0]           bus_wdata,
  output logic [PORT_W-1:0]           bus_rdata,
  input  logic [PORT_W*NUM_PORTS-1:0] pin_in,
  output logic [PORT_W*NUM_PORTS-1:0] pin_pull,
  output logic                        irq_out
);
  localparam int PIN_W    = PORT_W * NUM_PORTS;
  localparam int EDGE_W   = PORT_W * EDGE_PORTS;
  localparam int OFF_PEND = NUM_PORTS;
  localparam int OFF_PAGE = NUM_PORTS + 1;
  localparam int OFF_BANK = NUM_PORTS + 2;

  logic              wr_en;
  logic [PIN_W-1:0]  data_q, data_d;
  page_e             page_q, page_d;
  logic [PIN_W-1:0]  lvl_s;
  logic [EDGE_PORTS-1:0] pol_we, en_we, pend_vec;
  logic [EDGE_W-1:0] pol_flat, en_flat, id_flat;
  logic [PORT_W-1:0] rdata_c;

  assign wr_en = bus_sel & bus_wr;

  // R2: pin levels synchronised before reading or edge detection
  pgpio_sync #(.W(PIN_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (lvl_s)
  );

  // R1: data registers
  always_comb begin
    data_d = data_q;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (wr_en && bus_addr == ADDR_W'(i))
        data_d[i*PORT_W +: PORT_W] = bus_wdata;
    end
  end

  // R3: page register, only the top two bits are stored
  always_comb begin
    page_d = page_q;
    if (wr_en && bus_addr == ADDR_W'(OFF_PAGE))
      page_d = page_e'(bus_wdata[PORT_W-1 -: 2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      page_q <= PG_NONE;
    end else begin
      data_q <= data_d;
      page_q <= page_d;
    end
  end

  // R4: bank write strobes decoded from page and offset
  always_comb begin
    pol_we = '0;
    en_we  = '0;
    for (int p = 0; p < EDGE_PORTS; p++) begin
      if (wr_en && bus_addr == ADDR_W'(OFF_BANK + p)) begin
        pol_we[p] = (page_q == PG_POL);
        en_we[p]  = (page_q == PG_EN);
      end
    end
  end

  // R5: one edge bank per interrupt-capable port
  for (genvar p = 0; p < EDGE_PORTS; p++) begin : g_bank
    pgpio_edge_bank #(.W(PORT_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (lvl_s[p*PORT_W +: PORT_W]),
      .pol_we (pol_we[p]),
      .en_we  (en_we[p]),
      .wdata  (bus_wdata),
      .pol_q  (pol_flat[p*PORT_W +: PORT_W]),
      .en_q   (en_flat[p*PORT_W +: PORT_W]),
      .id_q   (id_flat[p*PORT_W +: PORT_W]),
      .pend   (pend_vec[p])
    );
  end

  // Read mux: R2, R3, R4, R7, R10
  always_comb begin
    rdata_c = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (bus_addr == ADDR_W'(i))
        rdata_c = lvl_s[i*PORT_W +: PORT_W];
    end
    if (bus_addr == ADDR_W'(OFF_PEND))
      rdata_c = PORT_W'(pend_vec);
    if (bus_addr == ADDR_W'(OFF_PAGE))
      rdata_c = {page_q, {(PORT_W-2){1'b0}}};
    for (int p = 0; p < EDGE_PORTS; p++) begin
      if (bus_addr == ADDR_W'(OFF_BANK + p)) begin
        case (page_q)
          PG_POL:  rdata_c = pol_flat[p*PORT_W +: PORT_W];
          PG_EN:   rdata_c = en_flat[p*PORT_W +: PORT_W];
          PG_ID:   rdata_c = id_flat[p*PORT_W +: PORT_W];
          default: rdata_c = '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_c;
  assign pin_pull  = data_q;
  // R8: single request line
  assign irq_out   = |pend_vec;
endmodule

// File: rtl/pgpio_ctrl_chk.sv
module pgpio_ctrl_chk #(
  parameter int PORT_W     = 8,
  parameter int NUM_PORTS  = 6,
  parameter int EDGE_PORTS = 3,
  parameter int ADDR_W     = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_sel,
  input logic                        bus_wr,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [PORT_W-1:0]           bus_wdata,
  input logic [PORT_W*NUM_PORTS-1:0] pin_pull,
  input logic                        irq_out,
  input logic [1:0]                  page,
  input logic [PORT_W*EDGE_PORTS-1:0] en_flat,
  input logic [PORT_W*EDGE_PORTS-1:0] id_flat
);
  localparam int OFF_PAGE = NUM_PORTS + 1;
  localparam int OFF_BANK = NUM_PORTS + 2;

  logic wr_en;
  assign wr_en = bus_sel & bus_wr;

  // R1: pin drive changes only through a write
  a_r1_pull_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_pull));

  // R3: page field changes only through a write to its offset
  a_r3_page_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && bus_addr == ADDR_W'(OFF_PAGE)) |=> $stable(page));

  // R9: no latched bit without its enable
  a_r9_id_within_en: assert property (@(posedge clk) disable iff (!rst_n)
    (id_flat & ~en_flat) == '0);

  // R5: a newly latched bit had its enable set in the cycle before
  a_r5_latch_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((id_flat & ~$past(id_flat) & ~$past(en_flat)) == '0));

  // R8: the request stays up until a write clears the cause
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !wr_en) |=> irq_out);

  // R6: writing enable bits as 0 clears those latched bits
  for (genvar p = 0; p < EDGE_PORTS; p++) begin : g_ack
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && page == 2'd2 && bus_addr == ADDR_W'(OFF_BANK + p))
      |=> ((id_flat[p*PORT_W +: PORT_W] & ~$past(bus_wdata)) == '0));
  end
endmodule

bind pgpio_ctrl pgpio_ctrl_chk #(
  .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .EDGE_PORTS(EDGE_PORTS), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_pull  (pin_pull),
  .irq_out   (irq_out),
  .page      (page_q),
  .en_flat   (en_flat),
  .id_flat   (id_flat)
);

// File: tb/pgpio_ctrl_bench.sv
module pgpio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_pull;
  logic        irq_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pgpio_ctrl u_pgpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_pull(pin_pull), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input string req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    check(req, {40'h0, bus_rdata}, {40'h0, exp});
    bus_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {write, offset, write data, expected read, requirement number}
  localparam int NV = 24;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 4'd7,  8'h00, 8'h00, 4'd3},  // R3 page resets to 0
    {1'b0, 4'd8,  8'h00, 8'h00, 4'd4},  // R4 page 0 reads 0
    {1'b1, 4'd8,  8'hFF, 8'h00, 4'd4},  // R4 page 0 write ignored
    {1'b1, 4'd7,  8'h7F, 8'h00, 4'd3},  // page 1, low bits dropped
    {1'b0, 4'd7,  8'h00, 8'h40, 4'd3},  // R3 readback
    {1'b0, 4'd8,  8'h00, 8'h00, 4'd4},  // R4 page-0 write did not land
    {1'b1, 4'd8,  8'hA5, 8'h00, 4'd4},
    {1'b0, 4'd8,  8'h00, 8'hA5, 4'd4},  // R4 polarity bank
    {1'b1, 4'd7,  8'h80, 8'h00, 4'd3},  // page 2
    {1'b0, 4'd8,  8'h00, 8'h00, 4'd9},  // R9 enable resets to 0
    {1'b0, 4'd10, 8'h00, 8'h00, 4'd9},
    {1'b1, 4'd9,  8'h3C, 8'h00, 4'd4},
    {1'b0, 4'd9,  8'h00, 8'h3C, 4'd4},  // R4 enable bank
    {1'b1, 4'd9,  8'h00, 8'h00, 4'd4},
    {1'b1, 4'd7,  8'hC0, 8'h00, 4'd3},  // page 3
    {1'b1, 4'd8,  8'hFF, 8'h00, 4'd4},
    {1'b0, 4'd8,  8'h00, 8'h00, 4'd4},  // R4 identification read only
    {1'b1, 4'd7,  8'h40, 8'h00, 4'd3},
    {1'b0, 4'd8,  8'h00, 8'hA5, 4'd4},  // polarity untouched by page 3 write
    {1'b1, 4'd6,  8'hFF, 8'h00, 4'd7},
    {1'b0, 4'd6,  8'h00, 8'h00, 4'd7},  // R7 offset 6 write ignored
    {1'b1, 4'd12, 8'hFF, 8'h00, 4'd10},
    {1'b0, 4'd12, 8'h00, 8'h00, 4'd10}, // R10 unused offsets read 0
    {1'b0, 4'd15, 8'h00, 8'h00, 4'd10}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 R8 R9 reset state
    check("R1 reset pull", pin_pull, 48'h0);
    check("R8 reset irq", {47'h0, irq_out}, 48'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VEC[i][3:0], i);
      if (VEC[i][24]) bus_write(VEC[i][23:20], VEC[i][19:12]);
      else bus_read(VEC[i][23:20], VEC[i][11:4], tag);
    end
    check("R10 no pull from unused write", pin_pull, 48'h0);

    // R1 data registers drive the pins
    bus_write(4'd0, 8'h5A);
    bus_write(4'd5, 8'h81);
    check("R1 pull ports 0 and 5", pin_pull, 48'h81_0000_0000_5A);

    // R2 read returns synchronised level, two edges of latency
    pin_in[47:40] = 8'h33;
    wait_cyc(1);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd5; #1;
    check("R2 level after one edge", {40'h0, bus_rdata}, 48'h81 & 48'h0);
    @(negedge clk);
    bus_read(4'd5, 8'h33, "R2 level after two edges");

    // R5 port 0: bit0 rising, bit1 falling, both enabled
    bus_write(4'd7, 8'h40); bus_write(4'd8, 8'h01);
    bus_write(4'd7, 8'h80); bus_write(4'd8, 8'h03);
    bus_write(4'd7, 8'hC0);
    pin_in[1:0] = 2'b11;
    wait_cyc(2);
    check("R5 no latch before third edge", {47'h0, irq_out}, 48'h0);
    wait_cyc(1);
    check("R5 latch at third edge", {47'h0, irq_out}, 48'h1);
    bus_read(4'd8, 8'h01, "R5 rising bit only");
    bus_read(4'd6, 8'h01, "R7 port 0 pending");
    pin_in[1] = 1'b0;
    wait_cyc(3);
    bus_read(4'd8, 8'h03, "R5 falling edge latched");

    // R6 acknowledge bit0, R8 irq held by bit1
    bus_write(4'd7, 8'h80); bus_write(4'd8, 8'h02);
    bus_write(4'd7, 8'hC0);
    bus_read(4'd8, 8'h02, "R6 clear one bit");
    check("R8 irq held", {47'h0, irq_out}, 48'h1);
    bus_write(4'd7, 8'h80); bus_write(4'd8, 8'h00);
    check("R8 irq drops when all cleared", {47'h0, irq_out}, 48'h0);
    bus_write(4'd8, 8'h03);
    check("R6 re-enable keeps cleared", {47'h0, irq_out}, 48'h0);

    // R5 ports 3 to 5 have no edge logic
    pin_in[39:24] = 16'hFFFF;
    wait_cyc(4);
    bus_read(4'd6, 8'h00, "R5 upper ports no pending");

    // R9 enable off: no latch on port 1
    bus_write(4'd7, 8'h40); bus_write(4'd9, 8'hFF);
    pin_in[8] = 1'b1;
    wait_cyc(4);
    bus_read(4'd6, 8'h00, "R9 disabled bit no latch");

    // R6 same-cycle: clear bit 16 while edges on 16 and 17 are detected
    bus_write(4'd10, 8'h07);
    bus_write(4'd7, 8'h80); bus_write(4'd10, 8'h03);
    pin_in[17:16] = 2'b11;
    wait_cyc(2);
    bus_write(4'd10, 8'h02);
    bus_write(4'd7, 8'hC0);
    bus_read(4'd10, 8'h02, "R6 clear wins, neighbour latches");

    // R6 same-cycle: enabling bit 18 while its edge is detected
    bus_write(4'd7, 8'h80);
    pin_in[18] = 1'b1;
    wait_cyc(2);
    bus_write(4'd10, 8'h06);
    bus_write(4'd7, 8'hC0);
    bus_read(4'd10, 8'h02, "R6 edge on enabling cycle not latched");

    // R9 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset pull", pin_pull, 48'h0);
    check("R9 reset irq", {47'h0, irq_out}, 48'h0);
    bus_read(4'd7, 8'h00, "R9 reset page");
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule